// File: doc/BRIEF.md
# Manchester Line Encoder with End-of-Frame Idle Shaping

This block turns a serial NRZ bit stream into Manchester line symbols for a 10 Mbit/s link. It runs from a 20 MHz reference clock. It divides that clock by two and returns the resulting bit-rate clock, `txClk`, to the data source. The source changes `txEn` and `txData` after each rising edge of `txClk`. The encoder samples both inputs on the reference edge at which `txClk` rises, which is the start of a bit cell. Each bit cell is two reference periods long, and each half cell lasts one period. A two-wire digital pair, `lineP` and `lineN`, models the differential line.

A frame runs for as long as `txEn` is sampled high at cell starts. When the first cell start with `txEn` low arrives, the encoder closes the frame with a positive transition and holds the line positive for a fixed number of half cells. It then settles into an idle level chosen by `stepSel`. In half-step mode the two wires are equal. In full-step mode `lineP` rests above `lineN`. A synchronous reset abandons any frame in progress and puts the pair at the idle level of the selected mode.

Top module: `mtxEncoder`

## Requirements
- R1: `txClk` is 0 while `rstN` is low. It goes to 1 on the first reference edge after reset is released and then changes level on every reference edge, so it runs at half the reference rate.
- R2: `txEn` and `txData` are sampled only on the reference edge at which `txClk` rises (a cell start). A change to either input that is sampled on any other edge has no effect on `lineP`/`lineN`.
- R3: A frame bit of 1 is driven as (`lineP`,`lineN`) = (0,1) for the first half cell and (1,0) for the second. A bit of 0 is driven as (1,0) and then (0,1). The first half appears on the same edge that samples the bit, and the second half follows one reference edge later.
- R4: At the first cell start with `txEn` sampled low after a frame, the pair goes to (1,0) on that edge and stays there for `HOLD_HALVES` half cells (default 4, i.e. 200 ns). This gives a positive final transition at mid-cell after a 1 and at the cell boundary after a 0.
- R5: In half-step mode (`stepSel` = 1), the idle level that follows the hold is (0,0).
- R6: In full-step mode (`stepSel` = 0), the idle level is (1,0).
- R7: During the hold period a high `txEn` is ignored. A new frame can start only from idle, at a cell start.
- R8: While `rstN` is low on a reference edge, the block drives `txClk` = 0 and the idle level of the current `stepSel` on the line pair, and it drops any frame in progress.
- R9: `lineP` and `lineN` are never both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 20 MHz reference clock; every register updates on its rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| txEn | input | 1 | Frame enable, sampled at cell starts |
| txData | input | 1 | NRZ data bit, sampled at cell starts |
| stepSel | input | 1 | Idle mode: 1 = half-step (equal wires), 0 = full-step (positive rest) |
| txClk | output | 1 | Bit-rate clock returned to the data source, reference divided by two |
| lineP | output | 1 | Positive wire of the modelled differential line |
| lineN | output | 1 | Negative wire of the modelled differential line |

## Verification
Every result is registered, so each one is due on a known reference edge. A sampled bit's first half appears on the sampling edge and its second half on the next edge. The hold starts on the edge that samples `txEn` low and lasts exactly `HOLD_HALVES` edges, and the idle level appears on the edge after that. The bench finds cell starts by waiting for a falling reference edge at which `txClk` is low, and it drives inputs there. It reads the outputs 1 ns after each rising edge and compares them against the half-cell value that edge is due to produce. That lets it prove that input changes sampled on mid-cell edges, or during the hold, leave the line unchanged.

// File: rtl/mtxPkg.sv
package mtxPkg;

  // Half-cell command from the control to the line datapath
  typedef struct packed {
    logic loadFirst;    // sample txData and drive first half of the cell
    logic driveSecond;  // drive second half of the stored bit
    logic driveHigh;    // end-of-frame positive hold
    logic driveIdle;    // mode-selected idle level
  } lineCmd_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_HOLD = 2'd2
  } txState_t;

endpackage

// File: rtl/mtxCtrl.sv
module mtxCtrl
  import mtxPkg::*;
#(
  parameter int HOLD_HALVES = 4
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     txEn,
  output logic     txClk,
  output lineCmd_t cmd
);

  localparam int CW = $clog2(HOLD_HALVES + 1);

  logic           phase;      // 0: next edge is a cell start
  txState_t       state, stateNext;
  logic [CW-1:0]  holdCnt, holdCntNext;

  always_comb begin
    cmd         = '0;
    stateNext   = state;
    holdCntNext = holdCnt;
    unique case (state)
      ST_IDLE: begin
        if (!phase && txEn) begin
          cmd.loadFirst = 1'b1;
          stateNext     = ST_SEND;
        end else begin
          cmd.driveIdle = 1'b1;
        end
      end
      ST_SEND: begin
        if (phase) begin
          cmd.driveSecond = 1'b1;
        end else if (txEn) begin
          cmd.loadFirst = 1'b1;
        end else begin
          cmd.driveHigh = 1'b1;
          stateNext     = ST_HOLD;
          holdCntNext   = CW'(HOLD_HALVES - 1);
        end
      end
      ST_HOLD: begin
        if (holdCnt == '0) begin
          cmd.driveIdle = 1'b1;
          stateNext     = ST_IDLE;
        end else begin
          cmd.driveHigh = 1'b1;
          holdCntNext   = holdCnt - 1'b1;
        end
      end
      default: begin
        cmd.driveIdle = 1'b1;
        stateNext     = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase   <= 1'b0;
      state   <= ST_IDLE;
      holdCnt <= '0;
    end else begin
      phase   <= !phase;
      state   <= stateNext;
      holdCnt <= holdCntNext;
    end
  end

  assign txClk = phase;

endmodule

// File: rtl/mtxLine.sv
module mtxLine
  import mtxPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     stepSel,
  input  logic     txData,
  input  lineCmd_t cmd,
  output logic     lineP,
  output logic     lineN
);

  logic bitReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitReg <= 1'b0;
      lineP  <= !stepSel;
      lineN  <= 1'b0;
    end else if (cmd.loadFirst) begin
      bitReg <= txData;
      lineP  <= !txData;
      lineN  <= txData;
    end else if (cmd.driveSecond) begin
      lineP  <= bitReg;
      lineN  <= !bitReg;
    end else if (cmd.driveHigh) begin
      lineP  <= 1'b1;
      lineN  <= 1'b0;
    end else begin
      lineP  <= !stepSel;
      lineN  <= 1'b0;
    end
  end

endmodule

// File: rtl/mtxEncoder.sv
module mtxEncoder
  import mtxPkg::*;
#(
  parameter int HOLD_HALVES = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic txEn,
  input  logic txData,
  input  logic stepSel,
  output logic txClk,
  output logic lineP,
  output logic lineN
);

  lineCmd_t cmd;

  mtxCtrl #(.HOLD_HALVES(HOLD_HALVES)) uCtrl (
    .clk   (clk),
    .rstN  (rstN),
    .txEn  (txEn),
    .txClk (txClk),
    .cmd   (cmd)
  );

  mtxLine uLine (
    .clk     (clk),
    .rstN    (rstN),
    .stepSel (stepSel),
    .txData  (txData),
    .cmd     (cmd),
    .lineP   (lineP),
    .lineN   (lineN)
  );

endmodule

// File: rtl/mtxEncoderChk.sv
module mtxEncoderChk #(
  parameter int HOLD_HALVES = 4
) (
  input logic clk,
  input logic rstN,
  input logic txClk,
  input logic lineP,
  input logic lineN
);

  logic [1:0] upCnt;      // cycles since reset release, saturating
  logic [7:0] highRun;    // consecutive cycles at (1,0), saturating
  logic       fromFrame;  // a frame symbol was seen since the last equal-wire idle

  always_ff @(posedge clk) begin
    if (!rstN) begin
      upCnt     <= '0;
      highRun   <= '0;
      fromFrame <= 1'b0;
    end else begin
      if (upCnt != 2'd3) upCnt <= upCnt + 1'b1;
      if (lineP && !lineN) begin
        if (highRun != 8'hFF) highRun <= highRun + 1'b1;
      end else begin
        highRun <= '0;
      end
      if (lineN) fromFrame <= 1'b1;
      else if (lineP == lineN) fromFrame <= 1'b0;
    end
  end

  // R1: bit clock changes level on every reference edge
  assert_clk_toggle_R1: assert property (@(posedge clk) disable iff (!rstN)
    (upCnt != 2'd0) |-> (txClk != $past(txClk)));

  // R9: wires never both high
  assert_no_both_high_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(lineP && lineN));

  // R3: a low first half (bit 1) is always followed by a high second half
  assert_one_completes_R3: assert property (@(posedge clk) disable iff (!rstN)
    ((upCnt != 2'd0) && $past(lineN) && $past(txClk)) |-> (lineP && !lineN));

  // R4: equal-wire idle after a frame only once the hold has lasted long enough
  assert_hold_length_R4: assert property (@(posedge clk) disable iff (!rstN)
    ((upCnt != 2'd0) && fromFrame && !lineP && !lineN && $past(lineP) && !$past(lineN))
      |-> (highRun >= 8'(HOLD_HALVES)));

endmodule

bind mtxEncoder mtxEncoderChk #(.HOLD_HALVES(HOLD_HALVES)) uChk (
  .clk   (clk),
  .rstN  (rstN),
  .txClk (txClk),
  .lineP (lineP),
  .lineN (lineN)
);

// File: tb/sim_mtxEncoder.sv
`timescale 1ns/1ps
module sim_mtxEncoder;

  localparam int HOLD = 4;

  logic clk = 1'b0;
  logic rstN, txEn, txData, stepSel;
  logic txClk, lineP, lineN;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mtxEncoder #(.HOLD_HALVES(HOLD)) u0 (
    .clk(clk), .rstN(rstN), .txEn(txEn), .txData(txData), .stepSel(stepSel),
    .txClk(txClk), .lineP(lineP), .lineN(lineN)
  );

  task automatic chkPair(input logic expP, input logic expN, input string req);
    checks++;
    if (lineP !== expP || lineN !== expN) begin
      failures++;
      $display("FAIL %s line got=%b%b exp=%b%b at %0t", req, lineP, lineN, expP, expN, $time);
    end
  endtask

  task automatic chkClk(input logic exp, input string req);
    checks++;
    if (txClk !== exp) begin
      failures++;
      $display("FAIL %s txClk got=%b exp=%b at %0t", req, txClk, exp, $time);
    end
  endtask

  // wait for the falling edge that precedes a cell start
  task automatic toCellStart();
    @(negedge clk);
    while (txClk !== 1'b0) @(negedge clk);
  endtask

  task automatic nextEdge();
    @(posedge clk);
    #1;
  endtask

  // R3 and R2: each bit, with txData flipped before the mid-cell edge
  task automatic sendBits(input logic [15:0] bits, input int n);
    for (int i = 0; i < n; i++) begin
      toCellStart();
      txEn = 1'b1;
      txData = bits[i];
      nextEdge();
      chkPair(!bits[i], bits[i], "R3 first half");
      @(negedge clk);
      txData = !bits[i];
      nextEdge();
      chkPair(bits[i], !bits[i], "R3/R2 second half");
    end
  endtask

  // R4 hold then R5/R6 idle; optional R7 poke during hold
  task automatic endFrame(input logic poke);
    toCellStart();
    txEn = 1'b0;
    for (int h = 0; h < HOLD; h++) begin
      nextEdge();
      chkPair(1'b1, 1'b0, "R4 hold");
      if (poke && h == 0) begin
        @(negedge clk);
        txEn = 1'b1;
        txData = 1'b1;
      end
    end
    nextEdge();
    chkPair(!stepSel, 1'b0, stepSel ? "R5/R7 idle" : "R6/R7 idle");
    if (poke) begin
      nextEdge();
      chkPair(!stepSel, 1'b0, "R2 no start mid-cell");
      nextEdge();
      chkPair(1'b0, 1'b1, "R7 start from idle");
      nextEdge();
      chkPair(1'b1, 1'b0, "R7 second half");
    end
  endtask

  task automatic testReset();
    rstN = 1'b0; txEn = 1'b0; txData = 1'b0; stepSel = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chkPair(1'b0, 1'b0, "R8/R5 reset half-step");
    chkClk(1'b0, "R8 reset clk");
    @(negedge clk); stepSel = 1'b0;
    nextEdge();
    chkPair(1'b1, 1'b0, "R8/R6 reset full-step");
    @(negedge clk); stepSel = 1'b1;
    nextEdge();
    @(negedge clk); rstN = 1'b1;
  endtask

  task automatic testClock();
    nextEdge();
    chkClk(1'b1, "R1 first edge");
    for (int k = 0; k < 6; k++) begin
      nextEdge();
      chkClk(k[0] ? 1'b1 : 1'b0, "R1 toggle");
    end
  endtask

  task automatic testHalfLastOne();
    stepSel = 1'b1;
    repeat (2) nextEdge();
    chkPair(1'b0, 1'b0, "R5 idle before frame");
    sendBits(16'b1011_0010_1101_0101, 16);
    endFrame(1'b0);
  endtask

  task automatic testHalfLastZero();
    stepSel = 1'b1;
    sendBits(16'b0000_0000_0011_0110, 10);
    endFrame(1'b0);
  endtask

  task automatic testFullStep();
    @(negedge clk); stepSel = 1'b0;
    repeat (2) nextEdge();
    chkPair(1'b1, 1'b0, "R6 idle before frame");
    sendBits(16'b0000_0000_1100_1001, 8);
    endFrame(1'b0);
    repeat (6) nextEdge();
    chkPair(1'b1, 1'b0, "R6 idle rest");
  endtask

  task automatic testHoldPoke();
    @(negedge clk); stepSel = 1'b1;
    sendBits(16'b0000_0000_0000_0110, 3);
    endFrame(1'b1);
    endFrame(1'b0);
  endtask

  task automatic testMidReset();
    stepSel = 1'b0;
    toCellStart();
    txEn = 1'b1; txData = 1'b0;
    nextEdge();
    chkPair(1'b1, 1'b0, "R3 zero first half");
    nextEdge();
    chkPair(1'b0, 1'b1, "R3 zero second half");
    @(negedge clk); rstN = 1'b0;
    nextEdge();
    chkPair(1'b1, 1'b0, "R8 mid-frame reset idle");
    chkClk(1'b0, "R8 mid-frame reset clk");
    @(negedge clk); rstN = 1'b1; txEn = 1'b0;
    nextEdge();
    chkClk(1'b1, "R1 after reset");
    repeat (4) begin
      nextEdge();
      chkPair(1'b1, 1'b0, "R8 frame dropped");
    end
  endtask

  initial begin
    testReset();
    testClock();
    testHalfLastOne();
    testHalfLastZero();
    testFullStep();
    testHoldPoke();
    testMidReset();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule